// File: doc/BRIEF.md
# Mixed-Width Dual-Clock FIFO

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. The two sides share a 4096-bit store and may use different word widths, each a power of two between 1 and 32 bits. Both positions are kept as bit addresses. A wide write word therefore lands in the store least-significant bit first, and a read word is assembled from consecutive bits in the same order.

Each side holds a word counter. The counter goes to the other clock domain as a Gray code with an extra wrap bit, through a two-flop synchronizer. The receiving side turns it back into a bit address. The number of stored bits is the difference of the two bit addresses, and all four flags come from it. Two 12-bit level inputs, given in bits, set where the almost-full and almost-empty flags switch.

Build-time options set three things:
- whether the read data passes through one extra register;
- whether the write counter halts at the full boundary or runs on;
- whether the read counter halts at the empty boundary or runs on.

When the read counter runs on, contents that were written once can be read again. Reset is synchronous and active low, and both clock domains sample it.

Top module: `mwfifo`

## Requirements
- R1: After reset, empty and aempty are high and full is low. afull is low when afull_lvl is nonzero.
- R2: The bits of write words are read back in write order. Write word bit 0 goes to the lowest bit address, and a read word takes its bit 0 from the lowest unread bit address.
- R3: empty is high whenever fewer bits are stored than one read word holds. With 2-bit writes and 4-bit reads, empty stays high after a single write.
- R4: full is high whenever the free space is smaller than one write word. With 4-bit writes and 2-bit reads, one read from a full FIFO leaves full high, and a second read clears it.
- R5: afull is high exactly when the stored bit count is greater than or equal to afull_lvl.
- R6: aempty is high exactly when the stored bit count is less than or equal to aempty_lvl.
- R7: With HALT_AT_EMPTY=1, a read request while empty does not move the read position and does not change dout.
- R8: With HALT_AT_EMPTY=0, a read request while empty advances the read position by one read word.
- R9: With HALT_AT_FULL=1, a write request while full is dropped and overwrites no stored data.
- R10: With HALT_AT_FULL=0, a write request while full advances the write position and overwrites the store at that position.
- R11: With PIPE_OUT=1, dout takes the new word one rclk edge after the accepting edge. With PIPE_OUT=0, dout changes on the accepting edge.
- R12: Each side's pointer crosses to the other clock as a Gray code that changes at most one bit per source clock. A write is reflected in empty within a few read clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low synchronous reset, sampled in both domains |
| we | input | 1 | Write request |
| din | input | WR_W | Write word |
| re | input | 1 | Read request |
| dout | output | RD_W | Read word |
| afull_lvl | input | 12 | Almost-full level in bits |
| aempty_lvl | input | 12 | Almost-empty level in bits |
| full | output | 1 | Less than one write word of free space (write domain) |
| afull | output | 1 | Stored bits at or above afull_lvl (write domain) |
| empty | output | 1 | Less than one read word stored (read domain) |
| aempty | output | 1 | Stored bits at or below aempty_lvl (read domain) |

## Verification
The bench exercises both width orderings, so it checks the partial-word rule for empty and for full. A design that compared against zero instead of the port width would drop empty after a lone 2-bit write, or drop full after a single 2-bit read. Random fills and drains move the level inputs to exactly the stored count and to one bit away from it. An off-by-one comparison therefore flips afull or aempty at the boundary. Directed requests at the empty and full boundaries show whether a stop option is honoured: a halted counter that still moved returns the wrong word on the next read, and a free-running counter that stopped leaves old data in place. The output stage is sampled between the accepting edge and the following edge, which separates a registered read path from an unregistered one.

// File: rtl/mwf_pkg.sv
// Shared constants and pointer conversions for the mixed-width FIFO.
// Assumes the store is a power of two in bits, addressed by AW bits.
package mwf_pkg;
    localparam int AW       = 12;
    localparam int PW       = AW + 1;
    localparam int MEM_BITS = 1 << AW;

    // Binary to reflected Gray code.
    function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/mwf_sync.sv
// Two-flop synchronizer for a Gray-coded pointer.
// Assumes at most one bit of d changes per source clock.
module mwf_sync #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mwf_wr_side.sv
// Write-side control: word counter, Gray pointer, full and almost-full flags.
// Assumes rgray_s is the read-side Gray word count already in the wclk domain.
module mwf_wr_side
    import mwf_pkg::*;
#(
    parameter int WR_W         = 2,
    parameter int RD_W         = 4,
    parameter bit HALT_AT_FULL = 1'b1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] afval,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          wacc,
    output logic          full,
    output logic          afull
);
    localparam int WSH = $clog2(WR_W);
    localparam int RSH = $clog2(RD_W);
    localparam int CW  = PW - WSH;

    logic [CW-1:0] wcnt;
    logic [PW-1:0] wbits, rbits, used;

    // Bit addresses from both counters and their distance.
    always_comb begin
        wbits = PW'(wcnt) << WSH;
        rbits = gray2bin(rgray_s) << RSH;
        used  = wbits - rbits;
    end

    assign full  = used > PW'(MEM_BITS - WR_W);
    assign afull = used >= {1'b0, afval};
    assign waddr = wbits[AW-1:0];
    assign wacc  = we && !(HALT_AT_FULL && full);

    // Advance the word counter and its Gray copy on an accepted write.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wcnt  <= '0;
            wgray <= '0;
        end else if (wacc) begin
            wcnt  <= wcnt + CW'(1);
            wgray <= bin2gray(PW'(wcnt + CW'(1)));
        end
    end

    // R9: a halted counter does not move while full.
    p_hold_full_r9: assert property (@(posedge wclk) disable iff (!rst_n)
        (HALT_AT_FULL && full && we) |=> (wcnt == $past(wcnt)));

    // R12: the crossing pointer changes at most one bit per clock.
    p_gray_step_r12: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R5: full implies afull whenever the level sits at or below the full point.
    p_full_afull_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && ({1'b0, afval} <= PW'(MEM_BITS - WR_W + 1))) |-> afull);
endmodule

// File: rtl/mwf_rd_side.sv
// Read-side control: word counter, Gray pointer, empty and almost-empty flags.
// Assumes wgray_s is the write-side Gray word count already in the rclk domain.
module mwf_rd_side
    import mwf_pkg::*;
#(
    parameter int WR_W          = 2,
    parameter int RD_W          = 4,
    parameter bit HALT_AT_EMPTY = 1'b1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] aeval,
    input  logic [PW-1:0] wgray_s,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic          racc,
    output logic          empty,
    output logic          aempty
);
    localparam int WSH = $clog2(WR_W);
    localparam int RSH = $clog2(RD_W);
    localparam int CW  = PW - RSH;

    logic [CW-1:0] rcnt;
    logic [PW-1:0] wbits, rbits, used;

    // Bit addresses from both counters and their distance.
    always_comb begin
        rbits = PW'(rcnt) << RSH;
        wbits = gray2bin(wgray_s) << WSH;
        used  = wbits - rbits;
    end

    assign empty  = used < PW'(RD_W);
    assign aempty = used <= {1'b0, aeval};
    assign raddr  = rbits[AW-1:0];
    assign racc   = re && !(HALT_AT_EMPTY && empty);

    // Advance the word counter and its Gray copy on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rcnt  <= '0;
            rgray <= '0;
        end else if (racc) begin
            rcnt  <= rcnt + CW'(1);
            rgray <= bin2gray(PW'(rcnt + CW'(1)));
        end
    end

    // R7: a halted counter does not move while empty.
    p_hold_empty_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        (HALT_AT_EMPTY && empty && re) |=> (rcnt == $past(rcnt)));

    // R12: the crossing pointer changes at most one bit per clock.
    p_gray_step_r12: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R6: empty implies aempty whenever the level covers a partial word.
    p_empty_aempty_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (empty && ({1'b0, aeval} >= PW'(RD_W - 1))) |-> aempty);
endmodule

// File: rtl/mwf_store.sv
// Bit-addressed storage with independent write and read word widths.
// Assumes addresses are aligned to their port width; contents are not reset.
module mwf_store
    import mwf_pkg::*;
#(
    parameter int WR_W     = 2,
    parameter int RD_W     = 4,
    parameter bit PIPE_OUT = 1'b1
) (
    input  logic            wclk,
    input  logic            wen,
    input  logic [AW-1:0]   waddr,
    input  logic [WR_W-1:0] wdata,
    input  logic            rclk,
    input  logic            rst_n,
    input  logic            ren,
    input  logic [AW-1:0]   raddr,
    output logic [RD_W-1:0] rdata
);
    logic [MEM_BITS-1:0] mem;
    logic [RD_W-1:0]     q_raw;

    // Place the write word at its bit address, LSB lowest.
    always_ff @(posedge wclk) begin
        if (wen) mem[waddr +: WR_W] <= wdata;
    end

    // Fetch the read word on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n)   q_raw <= '0;
        else if (ren) q_raw <= mem[raddr +: RD_W];
    end

    generate
        if (PIPE_OUT) begin : g_pipe
            logic [RD_W-1:0] q_pipe;
            // Extra output register stage.
            always_ff @(posedge rclk) begin
                if (!rst_n) q_pipe <= '0;
                else        q_pipe <= q_raw;
            end
            assign rdata = q_pipe;
        end else begin : g_flow
            assign rdata = q_raw;
        end
    endgenerate
endmodule

// File: rtl/mwfifo.sv
// Mixed-width dual-clock FIFO top: two control sides, two synchronizers, store.
// Assumes WR_W and RD_W are powers of two from 1 to 32.
module mwfifo
    import mwf_pkg::*;
#(
    parameter int WR_W          = 2,
    parameter int RD_W          = 4,
    parameter bit PIPE_OUT      = 1'b1,
    parameter bit HALT_AT_FULL  = 1'b1,
    parameter bit HALT_AT_EMPTY = 1'b1
) (
    input  logic            wclk,
    input  logic            rclk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [WR_W-1:0] din,
    input  logic            re,
    output logic [RD_W-1:0] dout,
    input  logic [AW-1:0]   afull_lvl,
    input  logic [AW-1:0]   aempty_lvl,
    output logic            full,
    output logic            afull,
    output logic            empty,
    output logic            aempty
);
    logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic          wacc, racc;

    mwf_wr_side #(.WR_W(WR_W), .RD_W(RD_W), .HALT_AT_FULL(HALT_AT_FULL)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .we(we), .afval(afull_lvl),
        .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .wacc(wacc),
        .full(full), .afull(afull)
    );

    mwf_rd_side #(.WR_W(WR_W), .RD_W(RD_W), .HALT_AT_EMPTY(HALT_AT_EMPTY)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .re(re), .aeval(aempty_lvl),
        .wgray_s(wgray_s), .rgray(rgray), .raddr(raddr), .racc(racc),
        .empty(empty), .aempty(aempty)
    );

    mwf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    mwf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    mwf_store #(.WR_W(WR_W), .RD_W(RD_W), .PIPE_OUT(PIPE_OUT)) u_mem (
        .wclk(wclk), .wen(wacc), .waddr(waddr), .wdata(din),
        .rclk(rclk), .rst_n(rst_n), .ren(racc), .raddr(raddr), .rdata(dout)
    );
endmodule

// File: tb/mwfifo_tb.sv
// Bench: instance u_dut (2-bit in, 4-bit out, piped, both halts) and
// instance u_dut_b (4-bit in, 2-bit out, unpiped, free-running counters).
module mwfifo_tb;
    logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    always #10 wclk = ~wclk;   // 50 MHz
    always #14 rclk = ~rclk;

    logic        a_we = 0, a_re = 0;
    logic [1:0]  a_din = 0;
    logic [3:0]  a_dout;
    logic [11:0] a_aft = 12'd100, a_aet = 12'd8;
    logic        a_full, a_afull, a_empty, a_aempty;

    logic        b_we = 0, b_re = 0;
    logic [3:0]  b_din = 0;
    logic [1:0]  b_dout;
    logic [11:0] b_aft = 12'd100, b_aet = 12'd0;
    logic        b_full, b_afull, b_empty, b_aempty;

    mwfifo #(.WR_W(2), .RD_W(4), .PIPE_OUT(1), .HALT_AT_FULL(1), .HALT_AT_EMPTY(1)) u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .we(a_we), .din(a_din), .re(a_re),
        .dout(a_dout), .afull_lvl(a_aft), .aempty_lvl(a_aet), .full(a_full),
        .afull(a_afull), .empty(a_empty), .aempty(a_aempty));

    mwfifo #(.WR_W(4), .RD_W(2), .PIPE_OUT(0), .HALT_AT_FULL(0), .HALT_AT_EMPTY(0)) u_dut_b (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .we(b_we), .din(b_din), .re(b_re),
        .dout(b_dout), .afull_lvl(b_aft), .aempty_lvl(b_aet), .full(b_full),
        .afull(b_afull), .empty(b_empty), .aempty(b_aempty));

    int n_chk = 0, n_bad = 0;
    bit mq[$];   // bit-level model of u_dut contents

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Expected flags from a stored bit count.
    function automatic bit exp_empty(int s, int rw);   return s < rw;           endfunction
    function automatic bit exp_full(int s, int ww);    return (4096 - s) < ww;  endfunction
    function automatic bit exp_afull(int s, int lvl);  return s >= lvl;        endfunction
    function automatic bit exp_aempty(int s, int lvl); return s <= lvl;        endfunction

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic a_wr(input logic [1:0] d);
        @(negedge wclk); a_din = d; a_we = 1'b1;
        @(negedge wclk); a_we = 1'b0;
    endtask

    task automatic a_rd(output logic [3:0] early, output logic [3:0] late);
        @(negedge rclk); a_re = 1'b1;
        @(negedge rclk); a_re = 1'b0; early = a_dout;
        @(negedge rclk); late = a_dout;
    endtask

    task automatic b_wr(input logic [3:0] d);
        @(negedge wclk); b_din = d; b_we = 1'b1;
        @(negedge wclk); b_we = 1'b0;
    endtask

    task automatic b_rd(output logic [1:0] q);
        @(negedge rclk); b_re = 1'b1;
        @(negedge rclk); b_re = 1'b0; q = b_dout;
    endtask

    function automatic logic [3:0] pop4();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = mq.pop_front();
        return v;
    endfunction

    task automatic a_flags(input string tag);
        int s = mq.size();
        chk({tag, " R3 empty"},  a_empty,  exp_empty(s, 4));
        chk({tag, " R4 full"},   a_full,   exp_full(s, 2));
        chk({tag, " R5 afull"},  a_afull,  exp_afull(s, a_aft));
        chk({tag, " R6 aempty"}, a_aempty, exp_aempty(s, a_aet));
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [3:0] e4, l4, x4;
        logic [1:0] q2;
        void'($urandom(32'd4242));
        repeat (6) @(negedge rclk);
        rst_n = 1'b1;
        @(negedge wclk);
        chk("R1 a empty", a_empty, 1); chk("R1 a aempty", a_aempty, 1);
        chk("R1 a full", a_full, 0);   chk("R1 a afull", a_afull, 0);
        chk("R1 b empty", b_empty, 1); chk("R1 b full", b_full, 0);
        chk("R1 b afull", b_afull, 0); chk("R1 b aempty", b_aempty, 1);

        // R3: one 2-bit word cannot satisfy a 4-bit read.
        a_wr(2'b01); mq.push_back(1); mq.push_back(0);
        settle();
        chk("R3 empty after one short write", a_empty, 1);
        a_wr(2'b11); mq.push_back(1); mq.push_back(1);
        settle();
        chk("R12 empty clears after crossing", a_empty, 0);
        x4 = pop4();
        a_rd(e4, l4);
        chk("R11 piped output not yet updated", e4, 4'h0);
        chk("R2 packed LSB first", l4, x4);

        // R7: read while empty is ignored.
        settle();
        @(negedge rclk); a_re = 1'b1;
        @(negedge rclk); a_re = 1'b0;
        repeat (2) @(negedge rclk);
        chk("R7 dout unchanged by read while empty", a_dout, 4'hD);
        a_wr(2'b10); mq.push_back(0); mq.push_back(1);
        a_wr(2'b00); mq.push_back(0); mq.push_back(0);
        settle();
        x4 = pop4();
        a_rd(e4, l4);
        chk("R11 piped output holds prior word", e4, 4'hD);
        chk("R7 read position held while empty", l4, x4);

        // Random fill/drain rounds with level boundaries (R2 R3 R4 R5 R6).
        for (int rnd = 0; rnd < 24; rnd++) begin
            int k, m, s;
            k = $urandom_range(0, 200);
            if (k > (4096 - mq.size()) / 2) k = (4096 - mq.size()) / 2;
            for (int i = 0; i < k; i++) begin
                logic [1:0] d = 2'($urandom);
                a_wr(d); mq.push_back(d[0]); mq.push_back(d[1]);
            end
            s = mq.size();
            if (rnd % 3 == 0) begin
                a_aft = (s == 0) ? 12'd1 : 12'(s); a_aet = 12'(s);
            end else if (rnd % 3 == 1 && s > 0) begin
                a_aft = 12'(s + 1); a_aet = 12'(s - 1);
            end else begin
                a_aft = 12'($urandom_range(1, 4095)); a_aet = 12'($urandom_range(0, 4095));
            end
            settle();
            a_flags("after writes");
            m = $urandom_range(0, 150);
            if (m > mq.size() / 4) m = mq.size() / 4;
            for (int i = 0; i < m; i++) begin
                x4 = pop4();
                a_rd(e4, l4);
                chk("R2 random read data", l4, x4);
            end
            settle();
            a_flags("after reads");
        end

        // R9: fill to full, then an extra write must be dropped.
        while (mq.size() < 4096) begin
            logic [1:0] d = 2'($urandom);
            a_wr(d); mq.push_back(d[0]); mq.push_back(d[1]);
        end
        a_aft = 12'd4095;
        settle();
        chk("R4 full at capacity", a_full, 1);
        chk("R5 afull at capacity", a_afull, 1);
        a_wr({~mq[1], ~mq[0]});
        settle();
        chk("R9 full held after dropped write", a_full, 1);
        begin
            int bad = 0;
            x4 = pop4();
            a_rd(e4, l4);
            chk("R9 oldest word not overwritten", l4, x4);
            while (mq.size() >= 4) begin
                x4 = pop4();
                a_rd(e4, l4);
                if (l4 !== x4) bad++;
            end
            chk("R9 drained data intact (mismatch count)", bad, 0);
        end
        settle();
        chk("R3 empty after drain", a_empty, 1);

        // R8: free-running read counter passes empty.
        b_rd(q2);
        b_wr(4'hA);
        settle();
        chk("R8 empty cleared with read ahead", b_empty, 0);
        b_rd(q2);
        chk("R8 read skipped first two bits", q2, 2'b10);

        // R4: 4-bit writes, 2-bit reads near full.
        for (int i = 0; i < 1024; i++) b_wr(4'((i * 7 + 3) & 15));
        settle();
        chk("R4 b full at capacity", b_full, 1);
        b_rd(q2);
        chk("R2 b first half word", q2, 2'b11);
        settle();
        chk("R4 full stays after one narrow read", b_full, 1);
        b_rd(q2);
        chk("R2 b second half word", q2, 2'b00);
        settle();
        chk("R4 full clears after a word of space", b_full, 0);

        // R10: free-running write counter passes full and overwrites.
        b_wr(4'hC);
        b_wr(4'h5);
        settle();
        b_rd(q2);
        chk("R10 overwrite visible at read position", q2, 2'b01);

        finish_run();
    end
endmodule